// File: doc/BRIEF.md
# I2C Byte-Memory Slave Controller

This block is the slave end of a two-wire serial bus, placed in front of a small on-chip byte array held in registers. The system clock runs much faster than the bus clock. The block oversamples the bus clock and data lines, picks out start and stop conditions, and decodes a fixed device address together with a direction bit. It then either takes in a word address and data bytes, or streams stored bytes back to the master. The block never drives the data line high. It pulls the line low through an output-enable, and an external pull-up supplies the high level.

A random read is done as a short write that only sets the word address, followed by a repeated start and a read address byte. Reads keep going from an internal pointer for as long as the master acknowledges each byte.

Top module: `i2cs_mem_slave`

## Requirements
- R1: Nothing is acknowledged or executed unless a start condition came first. A start is SDA falling while SCL is high.
- R2: A stop condition (SDA rising while SCL is high) ends the command. SDA is released, and later bytes sent without a new start get no acknowledge.
- R3: The address byte is matched only when its upper seven bits are 1010000. Bit 0 selects the direction: 0 is write, 1 is read. On a mismatch the block does not acknowledge and ignores the bus until the next start.
- R4: In a write, the first byte after the address byte is the word address. The block acknowledges it by holding SDA low during the ninth clock, and loads its ADDR_W low bits into the pointer.
- R5: Every following write byte is acknowledged and stored at the pointer. The pointer then increments and wraps from the last location to location 0.
- R6: A read returns the byte at the pointer, most significant bit first. SDA is released during the ninth clock, and the pointer advances after each byte.
- R7: When the master acknowledges (SDA low on the ninth clock), the next sequential byte follows, wrapping at the end of the array.
- R8: When the master does not acknowledge, the block stops driving and ignores further clocks until a stop or start.
- R9: A repeated start re-enters address reception from any state. A write that sets the word address, followed by a repeated start and a read, returns data from that address.
- R10: The output-enable changes only while SCL is low. Both inputs pass through a two-flop synchronizer.
- R11: After reset, SDA is released and every memory byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as sampled |
| sda_in | input | 1 | Bus data line as sampled (wired-AND value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with ADDR_W = 4, which gives a 16-byte array, and with a two-stage synchronizer. With only 16 locations, three writes starting at location 14 cross the wrap point, and a sequential read over the same span wraps as well. The bench runs each bus bit over 16 system clocks, so the synchronizer delay always settles inside one SCL phase. This lets the bench compare the output-enable against its bit-level model in the middle of every SCL high phase.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [6:0] DEV_ID = 7'b1010000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_WORD,
        ST_WRITE,
        ST_READ,
        ST_WAIT
    } st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b);
        return b[7:1] == DEV_ID;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [W-1:0] r;
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) r <= '1;
                    else     r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) r <= '1;
                    else     r <= g_stage[g-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/i2cs_busmon.sv
module i2cs_busmon
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    always_comb begin
        ev.start = scl & scl_d & sda_d & ~sda;
        ev.stop  = scl & scl_d & ~sda_d & sda;
        ev.rise  = scl & ~scl_d;
        ev.fall  = ~scl & scl_d;
    end
endmodule

// File: rtl/i2cs_bytes.sv
module i2cs_bytes #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [7:0]        wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [7:0]        rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];
endmodule

// File: rtl/i2cs_mem_slave.sv
module i2cs_mem_slave
    import i2cs_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(8);
    localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(9);

    logic              scl_s, sda_s;
    bus_ev_t           ev;
    st_e               st;
    logic [CNT_W-1:0]  bitcnt;
    logic [7:0]        shreg, tx, rd_data;
    logic [ADDR_W-1:0] ptr;
    logic              oe, we;

    i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q({scl_s, sda_s})
    );

    i2cs_busmon u_mon (
        .clk(clk), .rst(rst), .scl(scl_s), .sda(sda_s), .ev(ev)
    );

    assign we = (st == ST_WRITE) && ev.fall && (bitcnt == ACK_SLOT)
                && !ev.start && !ev.stop;

    i2cs_bytes #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst(rst), .we(we), .wa(ptr), .wd(shreg),
        .ra(ptr), .rd(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            tx     <= '0;
            ptr    <= '0;
            oe     <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_DEVADR;
            bitcnt <= '0;
            oe     <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            oe     <= 1'b0;
        end else begin
            case (st)
                ST_DEVADR, ST_WORD, ST_WRITE: begin
                    if (ev.rise && bitcnt < ACK_SLOT) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.fall && bitcnt == ACK_SLOT) begin
                        if (st == ST_DEVADR && !dev_match(shreg)) begin
                            st <= ST_IDLE;
                        end else begin
                            oe     <= 1'b1;
                            bitcnt <= ACK_END;
                            if (st == ST_WORD)  ptr <= shreg[ADDR_W-1:0];
                            if (st == ST_WRITE) ptr <= ptr + 1'b1;
                        end
                    end else if (ev.fall && bitcnt == ACK_END) begin
                        oe     <= 1'b0;
                        bitcnt <= '0;
                        if (st == ST_DEVADR) begin
                            if (shreg[0]) begin
                                st <= ST_READ;
                                tx <= rd_data;
                                oe <= ~rd_data[7];
                            end else begin
                                st <= ST_WORD;
                            end
                        end else begin
                            st <= ST_WRITE;
                        end
                    end
                end
                ST_READ: begin
                    if (ev.rise) begin
                        if (bitcnt < ACK_SLOT) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (bitcnt == ACK_SLOT) begin
                            if (!sda_s) begin
                                bitcnt <= ACK_END;
                            end else begin
                                st <= ST_WAIT;
                                oe <= 1'b0;
                            end
                        end
                    end else if (ev.fall) begin
                        if (bitcnt >= CNT_W'(1) && bitcnt < ACK_SLOT) begin
                            tx <= {tx[6:0], 1'b0};
                            oe <= ~tx[6];
                        end else if (bitcnt == ACK_SLOT) begin
                            oe  <= 1'b0;
                            ptr <= ptr + 1'b1;
                        end else if (bitcnt == ACK_END) begin
                            tx     <= rd_data;
                            oe     <= ~rd_data[7];
                            bitcnt <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = oe;

    AST_START_REARMS: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st == ST_DEVADR && bitcnt == '0 && !sda_oe)); // R9

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !ev.start) |=> (st == ST_IDLE && !sda_oe)); // R2

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE || st == ST_WAIT) |-> !sda_oe); // R3

    AST_WORD_ACKED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WORD && ev.fall && bitcnt == ACK_SLOT && !ev.start && !ev.stop) |=> sda_oe); // R4

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ && ev.rise && bitcnt == ACK_SLOT && sda_s && !ev.start && !ev.stop)
        |=> (st == ST_WAIT && !sda_oe)); // R8

    AST_PULL_ON_LOW_SCL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_s)); // R10

    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= ACK_END); // R6
endmodule

// File: tb/tb_i2cs_mem_slave.sv
module tb_i2cs_mem_slave;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_in;
    logic prev_oe = 1'b0;

    int vectors = 0;
    int miscomp = 0;

    logic [7:0] mem_m [16];
    int         ptr_m = 0;

    always #2.5 clk = ~clk;

    assign sda_in = sda_m & ~sda_oe;

    i2cs_mem_slave dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_in), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // R10: output-enable may only move while SCL is low
    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe) begin
            chk("R10", scl_m, 1'b0, "scl level at sda_oe change");
        end
        prev_oe = sda_oe;
    end

    task automatic slot(input logic mb, input logic exp_oe, input string req);
        scl_m = 1'b0;
        repeat (3) @(negedge clk);
        sda_m = mb;
        repeat (5) @(negedge clk);
        scl_m = 1'b1;
        repeat (5) @(negedge clk);
        chk(req, sda_oe, exp_oe, "sda_oe in scl high");
        repeat (3) @(negedge clk);
    endtask

    task automatic start_c();
        scl_m = 1'b0;
        repeat (8) @(negedge clk);
        sda_m = 1'b1;
        repeat (4) @(negedge clk);
        scl_m = 1'b1;
        repeat (8) @(negedge clk);
        sda_m = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic stop_c();
        scl_m = 1'b0;
        repeat (8) @(negedge clk);
        sda_m = 1'b0;
        repeat (4) @(negedge clk);
        scl_m = 1'b1;
        repeat (8) @(negedge clk);
        sda_m = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) slot(b[i], 1'b0, req);
        slot(1'b1, exp_ack, req);
    endtask

    task automatic set_word(input logic [7:0] w);
        send_byte(w, 1'b1, "R4");
        ptr_m = w % 16;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        send_byte(b, 1'b1, "R5");
        mem_m[ptr_m] = b;
        ptr_m = (ptr_m + 1) % 16;
    endtask

    task automatic rd_byte(input logic master_ack, input string req);
        logic [7:0] e;
        e = mem_m[ptr_m];
        for (int i = 7; i >= 0; i--) slot(1'b1, ~e[i], req);
        slot(master_ack ? 1'b0 : 1'b1, 1'b0, req);
        ptr_m = (ptr_m + 1) % 16;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscomp++;
        $display("FAIL all-requirements watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem_m[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R11", sda_oe, 1'b0, "sda_oe in reset");
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11", sda_oe, 1'b0, "sda_oe after reset");

        // R1: address byte without a start is ignored
        send_byte(8'hA0, 1'b0, "R1");

        // R4 R5: write three bytes from word 3
        start_c();
        send_byte(8'hA0, 1'b1, "R3");
        set_word(8'h03);
        wr_byte(8'h11);
        wr_byte(8'h22);
        wr_byte(8'h33);
        stop_c();

        // R2: after stop, bytes without start get no ack
        send_byte(8'hA0, 1'b0, "R2");
        send_byte(8'h03, 1'b0, "R2");

        // R3: select-bit and prefix mismatches
        start_c();
        send_byte(8'hA2, 1'b0, "R3");
        send_byte(8'hA0, 1'b0, "R3");
        stop_c();
        start_c();
        send_byte(8'hB0, 1'b0, "R3");
        stop_c();

        // R9 R6 R7 R8: random read of word 3
        start_c();
        send_byte(8'hA0, 1'b1, "R3");
        set_word(8'h03);
        start_c();
        send_byte(8'hA1, 1'b1, "R9");
        rd_byte(1'b1, "R6");
        rd_byte(1'b1, "R7");
        rd_byte(1'b0, "R7");
        send_byte(8'h00, 1'b0, "R8");
        stop_c();

        // R5: write across the wrap point
        start_c();
        send_byte(8'hA0, 1'b1, "R3");
        set_word(8'h0E);
        wr_byte(8'hAA);
        wr_byte(8'hBB);
        wr_byte(8'hCC);
        stop_c();

        // R7: sequential read across the wrap point
        start_c();
        send_byte(8'hA0, 1'b1, "R3");
        set_word(8'h0E);
        start_c();
        send_byte(8'hA1, 1'b1, "R9");
        rd_byte(1'b1, "R7");
        rd_byte(1'b1, "R7");
        rd_byte(1'b1, "R7");
        rd_byte(1'b0, "R8");
        stop_c();

        // R9: repeated start in the middle of a write, then read current pointer
        start_c();
        send_byte(8'hA0, 1'b1, "R3");
        set_word(8'h05);
        wr_byte(8'h77);
        start_c();
        send_byte(8'hA1, 1'b1, "R9");
        rd_byte(1'b1, "R11");
        rd_byte(1'b0, "R9");
        stop_c();

        // R6: read from current pointer without setting it
        start_c();
        send_byte(8'hA1, 1'b1, "R6");
        rd_byte(1'b0, "R6");
        stop_c();

        repeat (10) @(negedge clk);
        chk("R2", sda_oe, 1'b0, "sda_oe idle at end");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule